// File: doc/BRIEF.md
# SPI Master FIFO, Event and Interrupt Unit

This block sits between a host register bus and the serial shift engine of an SPI master. It buffers outgoing bytes in a 32-byte transmit queue and incoming bytes in a 32-byte receive queue. The host reaches both queues through data ports that take either 32-bit or 8-bit accesses. The shift engine takes bytes from the head of the transmit queue and appends received bytes to the receive queue, one byte at a time.

A latched event register shows the live byte counts of both queues and a set of status flags. The transmit count is the free space, not the fill level. Each flag is cleared by writing one to it. A mask register selects which flags drive a registered interrupt line. A control register holds the two threshold levels that the threshold flags compare against.

The register interface is a plain strobe bus with a single-cycle write and a read whose data is registered. The offsets are: control 0x00, event 0x04, mask 0x08, transmit data 0x0C, receive data 0x10.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Each queue holds exactly 32 bytes. A push to a full queue is dropped, whether it comes from the host or from the shift engine.
- R2: The event register reads the receive byte count in bits [29:24] and the transmit free space in bits [21:16]. The free space reads 32 when the transmit queue is empty.
- R3: Each event flag latches when its condition holds in a cycle: bit 15 transmit queue empty, bit 12 receive queue full (32 bytes), bit 9 receive queue not empty, bit 8 transmit queue not full. Bits 7..0 and 10 read zero.
- R4: The control register holds the transmit threshold in bits [13:8] and the receive threshold in bits [5:0]; after reset they are 4 and 15. Flag bit 13 latches while the receive count is greater than the receive threshold. Flag bit 11 latches while the transmit fill level is less than the transmit threshold.
- R5: Writing the event register clears every flag whose written bit is one. A flag whose condition still holds is set again on the next cycle.
- R6: The mask register uses the flag bit positions and resets to zero. The irq output is a register that goes high two cycles after a flag that is both set and unmasked appears, and falls again in the same way.
- R7: A 32-bit write to the transmit port pushes four bytes, bits [31:24] first, and is accepted only when at least four bytes are free; otherwise it is dropped whole. An 8-bit write pushes bits [7:0].
- R8: A 32-bit read of the receive port pops four bytes, the oldest in bits [31:24], only when at least four are present. An 8-bit read pops one byte into bits [7:0] with the upper bits zero. A read that cannot be served pops nothing and returns zero.
- R9: tx_byte shows the oldest transmit byte while tx_ready is high, and tx_pop removes it. rx_push appends rx_byte, and rx_room is high while the receive queue has space.
- R10: A one-cycle pulse on xfer_done latches flag bit 14.
- R11: After reset the register reads are: control 0x0000040F, event 0x00208900, mask 0. reg_rdata carries the data of a read on the cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wide | input | 1 | 1 = 32-bit access, 0 = 8-bit access (data ports only) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tx_ready | output | 1 | Transmit queue holds at least one byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Shift engine consumes tx_byte |
| rx_push | input | 1 | Shift engine delivers rx_byte |
| rx_byte | input | 8 | Received byte |
| rx_room | output | 1 | Receive queue is not full |
| xfer_done | input | 1 | Transfer-complete pulse from the shift engine |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that reg_wr and reg_rd are never high in the same cycle and that xfer_done is a single-cycle pulse. They also assume that tx_pop is raised only while tx_ready is high, so the shift engine never pops an empty transmit queue. The directed stimulus drives only one strobe at a time and pops the transmit queue only after it has seen tx_ready. It still pushes past a full queue and reads an empty one on purpose, because the block itself has to absorb those cases.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_CTRL = 5'h00;
  localparam logic [REG_AW-1:0] OFS_EVT  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_MASK = 5'h08;
  localparam logic [REG_AW-1:0] OFS_TXD  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_RXD  = 5'h10;

  // flag positions shared by event and mask registers
  localparam int unsigned FB_TX_EMPTY = 15;
  localparam int unsigned FB_DONE     = 14;
  localparam int unsigned FB_RX_THR   = 13;
  localparam int unsigned FB_RX_FULL  = 12;
  localparam int unsigned FB_TX_THR   = 11;
  localparam int unsigned FB_RX_AVAIL = 9;
  localparam int unsigned FB_TX_SPACE = 8;

  localparam logic [15:0] FLAG_BITS = 16'hFB00;

  localparam int unsigned RXCNT_LSB = 24;
  localparam int unsigned TXCNT_LSB = 16;
  localparam int unsigned TXTHR_LSB = 8;
  localparam int unsigned RXTHR_LSB = 0;
  localparam int unsigned CNT_FIELD = 6;

  localparam int unsigned TXTHR_RST = 4;
  localparam int unsigned RXTHR_RST = 15;

endpackage

// File: rtl/spi_byte_fifo.sv
// Byte queue built from LANES byte-wide banks so that up to LANES
// consecutive bytes can be written or read in a single cycle.
module spi_byte_fifo #(
  parameter  int DEPTH = 32,
  parameter  int LANES = 4,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int NW    = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NW-1:0]         push_n,
  input  logic [LANES-1:0][7:0] push_bytes,
  input  logic [NW-1:0]         pop_n,
  output logic [LANES-1:0][7:0] head_bytes,
  output logic [CW-1:0]         level
);

  localparam int AW   = $clog2(DEPTH);
  localparam int LW   = $clog2(LANES);
  localparam int ROWS = DEPTH / LANES;

  logic [AW-1:0]         wr_ptr;
  logic [AW-1:0]         rd_ptr;
  logic [LANES-1:0][7:0] bank_rd;

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [7:0]    mem [ROWS];
    logic [LW-1:0] w_lane;
    logic [AW-1:0] w_addr;
    logic          w_en;
    logic [LW-1:0] r_lane;
    logic [AW-1:0] r_addr;

    always_comb begin
      w_lane = LW'(b) - wr_ptr[LW-1:0];
      w_addr = wr_ptr + AW'(w_lane);
      w_en   = NW'(w_lane) < push_n;
      r_lane = LW'(b) - rd_ptr[LW-1:0];
      r_addr = rd_ptr + AW'(r_lane);
    end

    always_ff @(posedge clk) begin
      if (w_en) mem[w_addr[AW-1:LW]] <= push_bytes[w_lane];
    end

    assign bank_rd[b] = mem[r_addr[AW-1:LW]];
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      head_bytes[k] = bank_rd[LW'(rd_ptr[LW-1:0] + LW'(k))];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      level  <= level + CW'(push_n) - CW'(pop_n);
    end
  end

endmodule

// File: rtl/spi_evt_irq.sv
// Latched event flags with write-one-to-clear and a masked interrupt.
module spi_evt_irq
  import spi_fifo_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] tx_lvl,
  input  logic [CW-1:0] rx_lvl,
  input  logic [CW-1:0] tx_thr,
  input  logic [CW-1:0] rx_thr,
  input  logic          done_pulse,
  input  logic          clr_en,
  input  logic [15:0]   clr_bits,
  input  logic [15:0]   mask_bits,
  output logic [15:0]   flags,
  output logic          irq
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [15:0] cond;
  logic [15:0] keep;

  always_comb begin
    cond = '0;
    cond[FB_TX_EMPTY] = (tx_lvl == '0);
    cond[FB_DONE]     = done_pulse;
    cond[FB_RX_THR]   = (rx_lvl > rx_thr);
    cond[FB_RX_FULL]  = (rx_lvl == FULL);
    cond[FB_TX_THR]   = (tx_lvl < tx_thr);
    cond[FB_RX_AVAIL] = (rx_lvl != '0);
    cond[FB_TX_SPACE] = (tx_lvl != FULL);
    keep = clr_en ? ~clr_bits : '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= ((flags & keep) | cond) & FLAG_BITS;
      irq   <= |(flags & mask_bits);
    end
  end

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wide,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_ready,
  output logic [7:0]        tx_byte,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  output logic              rx_room,
  input  logic              xfer_done,
  output logic              irq
);

  localparam int LANES = DATA_W / 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NW    = $clog2(LANES + 1);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] WORDB = CW'(LANES);

  logic [CW-1:0]         tx_lvl, rx_lvl, tx_free;
  logic [CW-1:0]         thr_tx, thr_rx;
  logic [15:0]           mask_q, evt_flags;
  logic [NW-1:0]         tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [LANES-1:0][7:0] tx_in, rx_in, tx_head, rx_head;
  logic                  wr_txd, rd_rxd, wr_evt;
  logic [DATA_W-1:0]     rd_word;

  assign tx_free = FULL - tx_lvl;
  assign wr_txd  = reg_wr && (reg_addr == OFS_TXD);
  assign wr_evt  = reg_wr && (reg_addr == OFS_EVT);
  assign rd_rxd  = reg_rd && (reg_addr == OFS_RXD);

  // host side of the transmit queue: word writes are all-or-nothing
  always_comb begin
    tx_in     = '0;
    tx_push_n = '0;
    if (wr_txd) begin
      if (reg_wide) begin
        for (int k = 0; k < LANES; k++) tx_in[k] = reg_wdata[DATA_W-1-8*k -: 8];
        if (tx_free >= WORDB) tx_push_n = NW'(LANES);
      end else begin
        tx_in[0] = reg_wdata[7:0];
        if (tx_free != '0) tx_push_n = NW'(1);
      end
    end
    tx_pop_n = (tx_pop && tx_lvl != '0) ? NW'(1) : '0;
  end

  // shift-engine side of the receive queue, host reads
  always_comb begin
    rx_in     = '0;
    rx_in[0]  = rx_byte;
    rx_push_n = (rx_push && rx_lvl != FULL) ? NW'(1) : '0;
    rx_pop_n  = '0;
    if (rd_rxd) begin
      if (reg_wide) begin
        if (rx_lvl >= WORDB) rx_pop_n = NW'(LANES);
      end else if (rx_lvl != '0) begin
        rx_pop_n = NW'(1);
      end
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
    .clk        (clk),
    .rst        (rst),
    .push_n     (tx_push_n),
    .push_bytes (tx_in),
    .pop_n      (tx_pop_n),
    .head_bytes (tx_head),
    .level      (tx_lvl)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
    .clk        (clk),
    .rst        (rst),
    .push_n     (rx_push_n),
    .push_bytes (rx_in),
    .pop_n      (rx_pop_n),
    .head_bytes (rx_head),
    .level      (rx_lvl)
  );

  spi_evt_irq #(.DEPTH(DEPTH)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .tx_lvl     (tx_lvl),
    .rx_lvl     (rx_lvl),
    .tx_thr     (thr_tx),
    .rx_thr     (thr_rx),
    .done_pulse (xfer_done),
    .clr_en     (wr_evt),
    .clr_bits   (reg_wdata[15:0]),
    .mask_bits  (mask_q),
    .flags      (evt_flags),
    .irq        (irq)
  );

  // control and mask registers
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_tx <= CW'(TXTHR_RST);
      thr_rx <= CW'(RXTHR_RST);
      mask_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_CTRL) begin
        thr_tx <= reg_wdata[TXTHR_LSB +: CW];
        thr_rx <= reg_wdata[RXTHR_LSB +: CW];
      end
      if (reg_addr == OFS_MASK) mask_q <= reg_wdata[15:0] & FLAG_BITS;
    end
  end

  // read multiplexer
  always_comb begin
    rd_word = '0;
    unique case (reg_addr)
      OFS_CTRL: begin
        rd_word[TXTHR_LSB +: CW] = thr_tx;
        rd_word[RXTHR_LSB +: CW] = thr_rx;
      end
      OFS_EVT: begin
        rd_word[RXCNT_LSB +: CW] = rx_lvl;
        rd_word[TXCNT_LSB +: CW] = tx_free;
        rd_word[15:0]            = evt_flags;
      end
      OFS_MASK: rd_word[15:0] = mask_q;
      OFS_RXD: begin
        if (reg_wide && rx_lvl >= WORDB) begin
          for (int k = 0; k < LANES; k++) rd_word[DATA_W-1-8*k -: 8] = rx_head[k];
        end else if (!reg_wide && rx_lvl != '0) begin
          rd_word[7:0] = rx_head[0];
        end
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

  assign tx_ready = (tx_lvl != '0);
  assign tx_byte  = tx_head[0];
  assign rx_room  = (rx_lvl != FULL);

endmodule

// File: rtl/spi_fifo_irq_unit_chk.sv
module spi_fifo_irq_unit_chk
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_wide,
  input logic              rx_push,
  input logic              tx_pop,
  input logic              xfer_done,
  input logic [31:0]       reg_rdata,
  input logic [CW-1:0]     tx_lvl,
  input logic [CW-1:0]     rx_lvl,
  input logic [15:0]       evt_flags,
  input logic [15:0]       mask_q,
  input logic              irq
);

  p_tx_bound_r1: assert property (@(posedge clk) disable iff (rst)
    tx_lvl <= CW'(DEPTH));

  p_rx_bound_r1: assert property (@(posedge clk) disable iff (rst)
    rx_lvl <= CW'(DEPTH));

  p_tx_empty_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_lvl == '0) |=> evt_flags[FB_TX_EMPTY]);

  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(mask_q) != '0));

  p_word_push_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFS_TXD && reg_wide && !tx_pop &&
     tx_lvl <= CW'(DEPTH - 4)) |=> (tx_lvl == $past(tx_lvl) + CW'(4)));

  p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_RXD && rx_lvl == '0) |=> (reg_rdata == '0));

  p_rx_push_step_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_push && !reg_rd && rx_lvl != CW'(DEPTH)) |=> (rx_lvl == $past(rx_lvl) + CW'(1)));

  p_done_latch_r10: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> evt_flags[FB_DONE]);

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wide  (reg_wide),
  .rx_push   (rx_push),
  .tx_pop    (tx_pop),
  .xfer_done (xfer_done),
  .reg_rdata (reg_rdata),
  .tx_lvl    (tx_lvl),
  .rx_lvl    (rx_lvl),
  .evt_flags (evt_flags),
  .mask_q    (mask_q),
  .irq       (irq)
);

// File: tb/spi_fifo_irq_unit_tb.sv
module spi_fifo_irq_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_wide = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_ready, rx_room, irq;
  logic [7:0]  tx_byte;
  logic        tx_pop = 1'b0, rx_push = 1'b0, xfer_done = 1'b0;
  logic [7:0]  rx_byte = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_f = 1'b0;

  localparam logic [4:0] A_CTRL = 5'h00, A_EVT = 5'h04, A_MASK = 5'h08,
                         A_TXD = 5'h0C, A_RXD = 5'h10;

  always #4 clk = ~clk;

  spi_fifo_irq_unit u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wide(reg_wide), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_room(rx_room), .xfer_done(xfer_done), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d, input bit wide);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = wide;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, input bit wide, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a; reg_wide = wide;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic shift_in(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic shift_out(output logic [7:0] b);
    @(negedge clk);
    b = tx_byte;
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic clear_all_and_read(output logic [31:0] e);
    reg_write(A_EVT, 32'hFFFF_FFFF, 1'b1);
    idle(2);
    reg_read(A_EVT, 1'b1, e);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    idle(3);
    reg_read(A_CTRL, 1'b1, d); check("R11 ctrl reset / R4 thresholds", d, 32'h0000_040F);
    reg_read(A_EVT, 1'b1, d);  check("R11 event reset / R2 R3", d, 32'h0020_8900);
    reg_read(A_MASK, 1'b1, d); check("R11 mask reset", d, 32'h0);
    check("R6 irq low after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_tx_order;
    logic [7:0] b;
    logic [7:0] exp [5] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h5E};
    reg_write(A_TXD, 32'hA1B2_C3D4, 1'b1);
    reg_write(A_TXD, 32'h1234_565E, 1'b0);
    check("R9 tx_ready with data", {31'b0, tx_ready}, 32'h1);
    for (int i = 0; i < 5; i++) begin
      shift_out(b);
      check("R7 byte order / R9 pop", {24'b0, b}, {24'b0, exp[i]});
    end
    idle(1);
    check("R9 tx_ready after drain", {31'b0, tx_ready}, 32'h0);
  endtask

  task automatic t_tx_fill;
    logic [31:0] d;
    logic [7:0]  b;
    for (int k = 0; k < 8; k++) reg_write(A_TXD, 32'h0001_0203 + 32'h0404_0404 * k, 1'b1);
    reg_read(A_EVT, 1'b1, d);
    check("R2 tx free at full", (d >> 16) & 32'h3F, 32'd0);
    reg_write(A_TXD, 32'hDEAD_BEEF, 1'b1);
    reg_write(A_TXD, 32'h0000_00EE, 1'b0);
    clear_all_and_read(d);
    check("R1 R5 full tx, cleared flags stay clear", d, 32'h0);
    for (int i = 0; i < 32; i++) begin
      shift_out(b);
      check("R1 R7 tx drain content", {24'b0, b}, i);
    end
    idle(1);
    check("R1 no extra byte after 32", {31'b0, tx_ready}, 32'h0);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    for (int i = 0; i < 15; i++) shift_in(8'(i));
    clear_all_and_read(d);
    check("R4 rx count 15 not above threshold", d, 32'h0F20_8B00);
    shift_in(8'd15);
    clear_all_and_read(d);
    check("R4 rx threshold crossed", d, 32'h1020_AB00);
    for (int i = 16; i < 32; i++) shift_in(8'(i));
    check("R9 rx_room low at full", {31'b0, rx_room}, 32'h0);
    shift_in(8'd32);
    clear_all_and_read(d);
    check("R1 R3 rx full, extra push dropped", d, 32'h2020_BB00);
    reg_read(A_RXD, 1'b1, d); check("R8 word pop order", d, 32'h0001_0203);
    reg_read(A_RXD, 1'b0, d); check("R8 byte pop", d, 32'h0000_0004);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] s;
      s = 8'(5 + 4 * i);
      reg_read(A_RXD, 1'b1, d);
      check("R8 word pop sequence", d, {s, s + 8'd1, s + 8'd2, s + 8'd3});
    end
    reg_read(A_RXD, 1'b1, d); check("R8 short word read returns zero", d, 32'h0);
    reg_read(A_EVT, 1'b1, d); check("R8 short word read pops nothing", (d >> 24) & 32'h3F, 32'd3);
    for (int i = 29; i < 32; i++) begin
      reg_read(A_RXD, 1'b0, d); check("R8 byte pop tail", d, i);
    end
    reg_read(A_RXD, 1'b0, d); check("R8 empty byte read zero", d, 32'h0);
    reg_read(A_RXD, 1'b1, d); check("R8 empty word read zero", d, 32'h0);
  endtask

  task automatic t_thr;
    logic [31:0] d;
    logic [7:0]  b;
    reg_write(A_CTRL, 32'h0000_0A02, 1'b1);
    reg_read(A_CTRL, 1'b1, d); check("R4 ctrl readback", d, 32'h0000_0A02);
    for (int i = 0; i < 3; i++) shift_in(8'h40);
    for (int i = 0; i < 9; i++) reg_write(A_TXD, 32'h77, 1'b0);
    clear_all_and_read(d);
    check("R4 tx fill 9 below threshold 10", d, 32'h0317_2B00);
    reg_write(A_TXD, 32'h77, 1'b0);
    clear_all_and_read(d);
    check("R4 tx fill 10 not below threshold", d, 32'h0316_2300);
    for (int i = 0; i < 3; i++) reg_read(A_RXD, 1'b0, d);
    for (int i = 0; i < 10; i++) shift_out(b);
    reg_write(A_CTRL, 32'h0000_040F, 1'b1);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    reg_write(A_EVT, 32'hFFFF_FFFF, 1'b1);
    reg_write(A_MASK, 32'h0000_4000, 1'b1);
    idle(3);
    check("R6 masked-in flag clear, irq low", {31'b0, irq}, 32'h0);
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    idle(3);
    check("R6 R10 irq on done", {31'b0, irq}, 32'h1);
    reg_read(A_EVT, 1'b1, d); check("R10 done flag latched", d, 32'h0020_C900);
    reg_write(A_EVT, 32'h0000_4000, 1'b1);
    idle(3);
    check("R5 R6 irq drops after clear", {31'b0, irq}, 32'h0);
    reg_read(A_EVT, 1'b1, d); check("R5 only done cleared", d, 32'h0020_8900);
    reg_write(A_EVT, 32'h0000_8000, 1'b1);
    idle(2);
    reg_read(A_EVT, 1'b1, d); check("R5 live flag sets again", d & 32'h8000, 32'h8000);
    reg_write(A_MASK, 32'h0000_8000, 1'b1);
    idle(3);
    check("R6 irq from tx empty", {31'b0, irq}, 32'h1);
    reg_write(A_MASK, 32'h0, 1'b1);
    idle(3);
    check("R6 irq off when masked", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    idle(4);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_tx_order();
    t_tx_fill();
    t_rx();
    t_thr();
    t_irq();
    if (!done_f) begin
      done_f = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done_f) begin
      done_f = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule